// File: doc/BRIEF.md
# Cascadable Four-Bit Serializer

The block takes a 4-bit parallel word and sends it out one bit per rising edge of a fast bit clock, lowest bit first, as an NRZ stream. A phase counter driven by the same clock sets when a word is loaded. It also drives two registered divided clocks: one at a quarter of the bit rate and one at an eighth. Logic upstream can use these to present the next parallel word.

A mode input picks the frame length. With the mode low, a new word is loaded every four bit clocks and the serial input is never seen at the output. With the mode high, a load happens only once every eight bit clocks. For the four bit times after the local word, the shift register passes on bits taken from the serial input. Two devices wired output-to-input therefore form one 8-bit serializer. The downstream device sends its own four bits first and then the four bits of the upstream device.

A sync input clears the divider, the shift register and the divided clocks as soon as it is asserted, with no clock needed. Its release goes through a two-stage synchronizer, so conversion always restarts from a known phase with no runt pulse on the divided clocks.

Top module: `ser_cascade`

## Requirements
- R1: While `sync` is high (and two clock edges after it falls), `sout`, `div4_out` and `div8_out` are all low.
- R2: After `sync` falls, the first two rising edges of `clk` still leave the block in reset. The first word is loaded on the third rising edge, and `sout` shows bit 0 of that word right after it.
- R3: After a load edge, `sout` carries word bits 0, 1, 2, 3 on four consecutive edges, in that order.
- R4: With `mode8` low, a load happens on every fourth active edge (active edges 0, 4, 8, …), so words follow each other with no gap, and `sin` has no effect on `sout`.
- R5: With `mode8` high, a load happens only on active edges 0, 8, 16, …. After active edge e with e mod 8 ≥ 4, `sout` equals the value `sin` held at active edge e−3.
- R6: `div4_out` is registered. After active edge e it is high when e mod 4 is 0 or 1 and low otherwise, in both modes.
- R7: `div8_out` is registered. After active edge e it is high when e mod 8 is 0 to 3 and low otherwise, in both modes.
- R8: `pdata` is sampled only on a load edge. Changes on any other edge do not alter the bits being shifted out.
- R9: Raising `sync` between clock edges drives `sout`, `div4_out` and `div8_out` low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| sync | input | 1 | Asynchronous restart, active high, release synchronized |
| mode8 | input | 1 | 0: 4-bit frames, 1: 8-bit cascaded frames |
| pdata | input | 4 | Parallel word, bit 0 sent first |
| sin | input | 1 | Serial input from an upstream device |
| sout | output | 1 | Serial NRZ output |
| div4_out | output | 1 | Bit clock divided by four |
| div8_out | output | 1 | Bit clock divided by eight |

## Verification
The assertions assume that `mode8` stays constant between two assertions of `sync`, and that `sync` is raised at the start of the run so every flop has a known value. The stimulus changes `mode8` only while `sync` is held and raises `sync` at time zero. It changes `pdata` and `sin` on every cycle, away from the clock edge, so that the sampling window and the ignore rules are exercised.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // Level of a divided clock after the counter reaches value c.
  // High for the first half of each period that starts at count 1.
  function automatic logic div_level(input logic [2:0] c, input int lg);
    logic [2:0] d;
    d = c - 3'd1;
    return ~d[lg-1];
  endfunction
endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic sync_i,
  output logic rst_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge sync_i) begin
    if (sync_i) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain_q[STAGES-1];

  assert_release_clean_R2: assert property (@(posedge clk)
    $fell(rst_o) |-> !$past(sync_i));
endmodule

// File: rtl/ser_phase_gen.sv
module ser_phase_gen #(
  parameter int WORD_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic mode8,
  output logic load_stb,
  output logic div4_o,
  output logic div8_o
);
  import ser_pkg::*;
  localparam int CNT_W = $clog2(2 * WORD_W);

  logic [CNT_W-1:0] cnt_q, cnt_next;
  logic frame_start, word_start;

  assign cnt_next    = cnt_q + 1'b1;
  assign frame_start = (cnt_q == '0);
  assign word_start  = (cnt_q[CNT_W-2:0] == '0);
  assign load_stb    = !rst && (mode8 ? frame_start : word_start);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt_q  <= '0;
      div4_o <= 1'b0;
      div8_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_next;
      div4_o <= div_level(3'(cnt_next), CNT_W - 1);
      div8_o <= div_level(3'(cnt_next), CNT_W);
    end
  end

  assert_div_low_in_sync_R1: assert property (@(posedge clk)
    rst |-> (!div4_o && !div8_o));
  assert_div8_rise_at_frame_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(div8_o) |-> $past(frame_start));
  assert_div4_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(div8_o) |-> $rose(div4_o));
  assert_load_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    (load_stb && mode8) |=> !load_stb);
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] pdata,
  input  logic              sin,
  output logic              sout
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)           sh_q <= '0;
    else if (load_stb) sh_q <= pdata;
    else               sh_q <= {sin, sh_q[WORD_W-1:1]};
  end

  assign sout = sh_q[0];

  assert_sout_low_in_sync_R1: assert property (@(posedge clk)
    rst |-> !sout);
  assert_load_shows_bit0_R3: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> (sout == $past(pdata[0])));
endmodule

// File: rtl/ser_cascade.sv
module ser_cascade #(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              sync,
  input  logic              mode8,
  input  logic [WORD_W-1:0] pdata,
  input  logic              sin,
  output logic              sout,
  output logic              div4_out,
  output logic              div8_out
);
  logic rst_int;
  logic load_stb;

  ser_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .sync_i(sync), .rst_o(rst_int));

  ser_phase_gen #(.WORD_W(WORD_W)) u_phase (
    .clk(clk), .rst(rst_int), .mode8(mode8),
    .load_stb(load_stb), .div4_o(div4_out), .div8_o(div8_out));

  ser_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst_int), .load_stb(load_stb),
    .pdata(pdata), .sin(sin), .sout(sout));

  assert_sync_forces_low_R9: assert property (@(posedge clk)
    sync |-> (!sout && !div4_out && !div8_out));
endmodule

// File: tb/sim_ser_cascade.sv
module sim_ser_cascade;
  logic clk = 1'b0;
  logic sync = 1'b1;
  logic mode8 = 1'b0;
  logic [3:0] pdata = 4'd0;
  logic sin = 1'b0;
  logic sout, div4_out, div8_out;

  int checks = 0;
  int fails = 0;
  logic [3:0] pd_hist [0:127];
  logic       sin_hist[0:127];

  always #2.5 clk = ~clk;

  ser_cascade u0 (.clk(clk), .sync(sync), .mode8(mode8), .pdata(pdata),
                  .sin(sin), .sout(sout), .div4_out(div4_out), .div8_out(div8_out));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all_low(input string req);
    chk(req, sout, 1'b0);
    chk(req, div4_out, 1'b0);
    chk(req, div8_out, 1'b0);
  endtask

  task automatic run_mode(input logic m, input int n);
    // hold in reset, set mode
    @(posedge clk); #1;
    sync = 1'b1; mode8 = m;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk_all_low("R1");
    end
    for (int e = 0; e < n; e++) begin
      pd_hist[e]  = 4'((e * 7 + 3 + m * 5) % 16);
      sin_hist[e] = 1'(((e * 5) / 3 + e) % 2);
    end
    sync = 1'b0; pdata = pd_hist[0]; sin = sin_hist[0];
    @(posedge clk); #1; chk_all_low("R2");
    @(posedge clk); #1; chk_all_low("R2");
    for (int e = 0; e < n; e++) begin
      int p;
      logic exp_s;
      @(posedge clk); #1;
      p = m ? (e % 8) : (e % 4);
      if (p < 4) exp_s = pd_hist[e - p][p];
      else       exp_s = sin_hist[e - 3];
      if (e == 0)      chk("R2", sout, exp_s);
      else if (m)      chk("R5 R3 R8", sout, exp_s);
      else             chk("R4 R3 R8", sout, exp_s);
      chk("R6", div4_out, (e % 4) < 2);
      chk("R7", div8_out, (e % 8) < 4);
      if (e + 1 < n) begin
        pdata = pd_hist[e + 1];
        sin   = sin_hist[e + 1];
      end
    end
    // asynchronous restart between edges
    @(posedge clk); #1;
    while (!div4_out) begin @(posedge clk); #1; end
    sync = 1'b1;
    #1;
    chk_all_low("R9");
  endtask

  initial begin
    #1;
    chk_all_low("R1");
    run_mode(1'b0, 64);
    run_mode(1'b1, 64);
    run_mode(1'b0, 40);
    // R4: all-ones sin against zero words in 4-bit mode
    @(posedge clk); #1;
    sync = 1'b1; mode8 = 1'b0;
    @(posedge clk); #1;
    sync = 1'b0; pdata = 4'd0; sin = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    for (int e = 0; e < 16; e++) begin
      @(posedge clk); #1;
      chk("R4", sout, 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule